// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects 63 level-sensitive interrupt requests and tells a processor core, as a 3-bit priority level, how urgent the most urgent unmasked request is. The core then acknowledges, either by a hardware acknowledge cycle that names a level or by a software acknowledge read. Each acknowledge returns a vector number unique to the winning source, or a spurious vector when nothing qualifies.

Sources 0 to 55 are programmable: software gives each a level from 1 to 7 and a priority from 0 to 7 within that level. Level 0 turns the source off. Sources 56 to 62 have fixed levels: source 56+k sits at level k+1, with a fixed rank between programmable priorities 3 and 4. Every source has its own mask bit, and one mask-all bit blocks all of them. An acknowledge does not clear a request. A request stays pending until the source drops its own line. A combinational wake output lets the core leave a low-power state without a running clock.

Top module: `lvl_intc`

## Requirements
- R1: After reset, ipl_o is 0, ack_valid_o is 0 and wake_o is 0. Every per-source mask bit is set, mask-all is clear, and every programmable level is 0.
- R2: Two clock edges after a request or a configuration change, ipl_o equals the highest level among eligible sources, or 0 if none is eligible. A source is eligible when its request is registered, it is unmasked, mask-all is clear and its level is not 0.
- R3: Within one level, a higher priority value wins. A fixed-level source ranks above programmable priorities 0 to 3 and below priorities 4 to 7.
- R4: When two eligible sources have the same level and priority, the lower source number wins.
- R5: A hardware acknowledge (hw_ack_i with level hw_ack_lvl_i) makes ack_valid_o high for one cycle after the edge that samples it. ack_vector_o then carries VEC_BASE (64) plus the number of the winning source at that level.
- R6: A hardware acknowledge of a level with no eligible source returns the spurious vector VEC_SPUR (24).
- R7: A software acknowledge (sw_ack_i) returns the vector of the overall winner, at the highest level, or 24 if no source is eligible. When both acknowledges arrive in the same cycle, only the hardware one is answered.
- R8: A masked source contributes to neither ipl_o, acknowledge results nor wake_o.
- R9: While mask-all is set, ipl_o is 0, wake_o is 0 and a software acknowledge returns 24. Clearing mask-all restores the previous arbitration.
- R10: An acknowledge does not clear a request. ipl_o stays unchanged while the request is held, and falls only after the request line drops.
- R11: wake_o is combinational from irq_i. It rises in the same cycle as an unmasked, enabled request, before any clock edge.
- R12: pending_o shows each raw request one clock edge after it is applied, regardless of mask.
- R13: Writes use wr_kind_i. Kind 0 sets level (wr_data_i[5:3]) and priority (wr_data_i[2:0]) of source wr_idx_i; it has effect only for sources 0 to 55, so the fixed sources ignore it. Kind 1 sets the mask bit of wr_idx_i to wr_data_i[0]. Kind 2 sets mask-all to wr_data_i[0]. Kind 3 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 63 | Level-sensitive request per source |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_kind_i | input | 2 | Write kind: 0 level/priority, 1 mask bit, 2 mask-all |
| wr_idx_i | input | 6 | Source addressed by the write |
| wr_data_i | input | 6 | Write data: [5:3] level, [2:0] priority, or [0] mask |
| pending_o | output | 63 | Registered raw requests |
| ipl_o | output | 3 | Highest eligible level, 0 when none |
| wake_o | output | 1 | Combinational any-unmasked-request |
| hw_ack_i | input | 1 | Hardware acknowledge strobe |
| hw_ack_lvl_i | input | 3 | Level being acknowledged |
| sw_ack_i | input | 1 | Software acknowledge read strobe |
| ack_valid_o | output | 1 | Acknowledge answer valid, one cycle |
| ack_vector_o | output | 8 | Returned vector number |

## Verification
The assertions assume that requests are held level-sensitive until serviced, and that write indices stay below 63. They also assume that the hardware acknowledge level is sampled only together with its strobe. The stimulus changes inputs only on the falling clock edge. It holds each request until it is deliberately dropped, and it waits two edges after any change before it acknowledges. Every acknowledge therefore sees settled arbitration. The one simultaneous hardware-and-software acknowledge is issued on purpose, to check the precedence rule.

// File: rtl/lvl_intc_pkg.sv
// Shared definitions for the leveled interrupt controller.
// Assumes: users import it; holds only the write-kind encoding.
package lvl_intc_pkg;
    typedef enum logic [1:0] {
        KIND_PRIO    = 2'd0,
        KIND_MASK    = 2'd1,
        KIND_MASKALL = 2'd2,
        KIND_NONE    = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/lvl_intc_cfg.sv
// Configuration store: programmable levels/priorities, per-source masks,
// mask-all. Fixed-level sources get constant levels 1..N_LEVELS.
// Assumes: wr_idx_i below N_SRC; out-of-range writes are dropped.
module lvl_intc_cfg
    import lvl_intc_pkg::*;
#(
    parameter int N_PROG   = 56,
    parameter int N_LEVELS = 7,
    parameter int LVL_W    = 3,
    parameter int PRI_W    = 3,
    parameter int IDX_W    = 6,
    localparam int N_SRC   = N_PROG + N_LEVELS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en_i,
    input  logic [1:0]                      wr_kind_i,
    input  logic [IDX_W-1:0]                wr_idx_i,
    input  logic [LVL_W+PRI_W-1:0]          wr_data_i,
    output logic [N_SRC-1:0][LVL_W-1:0]     lvl_o,
    output logic [N_PROG-1:0][PRI_W-1:0]    pri_o,
    output logic [N_SRC-1:0]                mask_o,
    output logic                            mask_all_o
);
    logic [N_PROG-1:0][LVL_W-1:0] plvl_q;
    logic [N_PROG-1:0][PRI_W-1:0] ppri_q;
    logic [N_SRC-1:0]             mask_q;
    logic                         mask_all_q;
    wr_kind_e                     kind;

    assign kind = wr_kind_e'(wr_kind_i);

    // Apply one configuration write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plvl_q     <= '0;
            ppri_q     <= '0;
            mask_q     <= '1;
            mask_all_q <= 1'b0;
        end else if (wr_en_i) begin
            case (kind)
                KIND_PRIO: if (wr_idx_i < IDX_W'(N_PROG)) begin
                    plvl_q[wr_idx_i] <= wr_data_i[LVL_W+PRI_W-1:PRI_W];
                    ppri_q[wr_idx_i] <= wr_data_i[PRI_W-1:0];
                end
                KIND_MASK: if (wr_idx_i < IDX_W'(N_SRC))
                    mask_q[wr_idx_i] <= wr_data_i[0];
                KIND_MASKALL: mask_all_q <= wr_data_i[0];
                default: ;
            endcase
        end
    end

    // Level table: programmable entries from storage, fixed ones constant.
    for (genvar i = 0; i < N_PROG; i++) begin : g_prog
        assign lvl_o[i] = plvl_q[i];
    end
    for (genvar k = 0; k < N_LEVELS; k++) begin : g_fixed
        assign lvl_o[N_PROG+k] = LVL_W'(k + 1);
    end

    assign pri_o      = ppri_q;
    assign mask_o     = mask_q;
    assign mask_all_o = mask_all_q;

    a_r13_maskall_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && kind == KIND_MASKALL) |=> (mask_all_o == $past(wr_data_i[0])));
    a_r13_prio_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && kind == KIND_PRIO && wr_idx_i < IDX_W'(N_PROG))
        |=> (lvl_o[$past(wr_idx_i)] == $past(wr_data_i[LVL_W+PRI_W-1:PRI_W])));
endmodule

// File: rtl/lvl_intc_arb.sv
// Combinational max-finder: picks the eligible source with the largest
// key; on equal keys the lowest index wins (strict compare, ascending scan).
// Assumes: keys already encode level above rank.
module lvl_intc_arb #(
    parameter int N_SRC = 63,
    parameter int IDX_W = 6,
    parameter int KEY_W = 7
) (
    input  logic [N_SRC-1:0]            elig_i,
    input  logic [N_SRC-1:0][KEY_W-1:0] key_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            idx_o
);
    logic [KEY_W-1:0] best;

    // Linear scan keeping the first strict maximum.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (!found_o || key_i[i] > best)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = key_i[i];
            end
        end
    end
endmodule

// File: rtl/lvl_intc.sv
// Leveled priority interrupt controller top. Registers raw requests,
// arbitrates by level then rank, drives ipl_o, answers hardware and
// software acknowledges with vectors, and drives a clockless wake line.
// Assumes: requests are level-held by their sources; acknowledges never
// clear them.
module lvl_intc #(
    parameter int N_LEVELS     = 7,
    parameter int PROG_PER_LVL = 8,
    parameter int VEC_W        = 8,
    parameter int VEC_BASE     = 64,
    parameter int VEC_SPUR     = 24,
    localparam int N_PROG = N_LEVELS * PROG_PER_LVL,
    localparam int N_SRC  = N_PROG + N_LEVELS,
    localparam int IDX_W  = $clog2(N_SRC),
    localparam int LVL_W  = $clog2(N_LEVELS + 1),
    localparam int PRI_W  = $clog2(PROG_PER_LVL),
    localparam int CFG_W  = LVL_W + PRI_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   irq_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_kind_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [CFG_W-1:0]   wr_data_i,
    output logic [N_SRC-1:0]   pending_o,
    output logic [LVL_W-1:0]   ipl_o,
    output logic               wake_o,
    input  logic               hw_ack_i,
    input  logic [LVL_W-1:0]   hw_ack_lvl_i,
    input  logic               sw_ack_i,
    output logic               ack_valid_o,
    output logic [VEC_W-1:0]   ack_vector_o
);
    localparam int RANK_W = PRI_W + 1;
    localparam int KEY_W  = LVL_W + RANK_W;
    localparam int HALF   = PROG_PER_LVL / 2;

    logic [N_SRC-1:0][LVL_W-1:0]  lvl_w;
    logic [N_PROG-1:0][PRI_W-1:0] pri_w;
    logic [N_SRC-1:0]             mask_w;
    logic                         mask_all_w;
    logic [N_SRC-1:0]             pend_q;
    logic [N_SRC-1:0]             enab, elig, elig_hw;
    logic [N_SRC-1:0][KEY_W-1:0]  key;
    logic                         glb_found, hw_found;
    logic [IDX_W-1:0]             glb_idx, hw_idx;
    logic [LVL_W-1:0]             ipl_q;
    logic                         ack_vld_q;
    logic [VEC_W-1:0]             ack_vec_q;

    lvl_intc_cfg #(
        .N_PROG(N_PROG), .N_LEVELS(N_LEVELS), .LVL_W(LVL_W),
        .PRI_W(PRI_W), .IDX_W(IDX_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .lvl_o(lvl_w),
        .pri_o(pri_w), .mask_o(mask_w), .mask_all_o(mask_all_w)
    );

    // Capture raw requests once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_i;
    end

    // Arbitration keys: level on top, rank below; fixed sources rank mid-level.
    for (genvar i = 0; i < N_SRC; i++) begin : g_key
        logic [RANK_W-1:0] rank;
        if (i < N_PROG) begin : g_p
            assign rank = (pri_w[i] < PRI_W'(HALF)) ? RANK_W'(pri_w[i])
                                                     : RANK_W'(pri_w[i]) + RANK_W'(1);
        end else begin : g_f
            assign rank = RANK_W'(HALF);
        end
        assign enab[i]    = (lvl_w[i] != '0);
        assign elig[i]    = pend_q[i] & ~mask_w[i] & ~mask_all_w & enab[i];
        assign elig_hw[i] = elig[i] & (lvl_w[i] == hw_ack_lvl_i);
        assign key[i]     = {lvl_w[i], rank};
    end

    lvl_intc_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_arb_glb (
        .elig_i(elig), .key_i(key), .found_o(glb_found), .idx_o(glb_idx)
    );
    lvl_intc_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_arb_hw (
        .elig_i(elig_hw), .key_i(key), .found_o(hw_found), .idx_o(hw_idx)
    );

    // Register the presented level of the overall winner.
    always_ff @(posedge clk) begin
        if (!rst_n) ipl_q <= '0;
        else        ipl_q <= glb_found ? lvl_w[glb_idx] : '0;
    end

    // Answer acknowledges; hardware cycle takes precedence over software read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld_q <= 1'b0;
            ack_vec_q <= '0;
        end else if (hw_ack_i) begin
            ack_vld_q <= 1'b1;
            ack_vec_q <= hw_found ? VEC_W'(VEC_BASE) + VEC_W'(hw_idx) : VEC_W'(VEC_SPUR);
        end else if (sw_ack_i) begin
            ack_vld_q <= 1'b1;
            ack_vec_q <= glb_found ? VEC_W'(VEC_BASE) + VEC_W'(glb_idx) : VEC_W'(VEC_SPUR);
        end else begin
            ack_vld_q <= 1'b0;
        end
    end

    assign wake_o       = (|(irq_i & ~mask_w & enab)) & ~mask_all_w;
    assign pending_o    = pend_q;
    assign ipl_o        = ipl_q;
    assign ack_valid_o  = ack_vld_q;
    assign ack_vector_o = ack_vec_q;

    a_r5_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> $past(hw_ack_i || sw_ack_i));
    a_r9_maskall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mask_all_w |=> (ipl_o == '0));
    a_r2_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        glb_found |-> (pend_q[glb_idx] && lvl_w[glb_idx] != '0));
    a_r8_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
        glb_found |-> !mask_w[glb_idx]);
    a_r6_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ack_i && !(|elig_hw)) |=> (ack_vector_o == VEC_W'(VEC_SPUR)));
    a_r5_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && ack_vector_o != VEC_W'(VEC_SPUR))
        |-> (ack_vector_o >= VEC_W'(VEC_BASE) && ack_vector_o < VEC_W'(VEC_BASE + N_SRC)));
endmodule

// File: tb/tb_lvl_intc.sv
module tb_lvl_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [62:0] irq_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_kind_i = '0;
    logic [5:0]  wr_idx_i = '0;
    logic [5:0]  wr_data_i = '0;
    logic [62:0] pending_o;
    logic [2:0]  ipl_o;
    logic        wake_o;
    logic        hw_ack_i = 1'b0;
    logic [2:0]  hw_ack_lvl_i = '0;
    logic        sw_ack_i = 1'b0;
    logic        ack_valid_o;
    logic [7:0]  ack_vector_o;

    int n_vec = 0;
    int n_bad = 0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    lvl_intc dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en_i(wr_en_i),
        .wr_kind_i(wr_kind_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .pending_o(pending_o), .ipl_o(ipl_o), .wake_o(wake_o),
        .hw_ack_i(hw_ack_i), .hw_ack_lvl_i(hw_ack_lvl_i), .sw_ack_i(sw_ack_i),
        .ack_valid_o(ack_valid_o), .ack_vector_o(ack_vector_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: pops one expected vector per acknowledge answer.
    always @(negedge clk) begin
        if (rst_n && ack_valid_o) begin
            if (exp_q.size() == 0) check("R5 unexpected ack", int'(ack_vector_o), -1);
            else check(tag_q.pop_front(), int'(ack_vector_o), exp_q.pop_front());
        end
    end

    task automatic wr(input int kind, input int idx, input int data);
        wr_en_i = 1'b1; wr_kind_i = 2'(kind); wr_idx_i = 6'(idx); wr_data_i = 6'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic prio(input int idx, input int lvl, input int pr);
        wr(0, idx, lvl * 8 + pr);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // Driver: issues an acknowledge and pushes the expected vector.
    task automatic ack(input bit hw, input bit sw, input int lvl, input int expv, input string tag);
        hw_ack_i = hw; sw_ack_i = sw; hw_ack_lvl_i = 3'(lvl);
        exp_q.push_back(expv); tag_q.push_back(tag);
        @(negedge clk);
        hw_ack_i = 1'b0; sw_ack_i = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        check("watchdog", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ipl", int'(ipl_o), 0);
        check("R1 ack_valid", int'(ack_valid_o), 0);
        check("R1 wake", int'(wake_o), 0);

        // R12 and level 0 disables (R13/R1)
        irq_i[5] = 1'b1;
        @(negedge clk);
        check("R12 pending", int'(pending_o[5]), 1);
        wr(1, 5, 0);
        settle();
        check("R13 level0 off", int'(ipl_o), 0);

        // R1 reset mask set
        prio(7, 2, 0);
        irq_i[7] = 1'b1;
        settle();
        check("R1 masked at reset", int'(ipl_o), 0);
        check("R1 wake masked", int'(wake_o), 0);
        wr(1, 7, 0);
        settle();
        check("R2 ipl level2", int'(ipl_o), 2);
        check("R8 wake unmasked", int'(wake_o), 1);

        prio(5, 3, 2);
        settle();
        check("R2 ipl level3", int'(ipl_o), 3);
        ack(1, 0, 3, 69, "R5 hw ack L3");
        ack(1, 0, 2, 71, "R5 hw ack L2");
        ack(1, 0, 4, 24, "R6 spurious L4");

        // R3 priority and fixed rank
        prio(10, 3, 5); wr(1, 10, 0); irq_i[10] = 1'b1;
        wr(1, 58, 0); irq_i[58] = 1'b1;
        settle();
        ack(1, 0, 3, 74, "R3 prio5 over fixed");
        irq_i[10] = 1'b0;
        settle();
        ack(1, 0, 3, 122, "R3 fixed over prio2");
        prio(11, 3, 4); wr(1, 11, 0); irq_i[11] = 1'b1;
        settle();
        ack(1, 0, 3, 75, "R3 prio4 over fixed");
        irq_i[11] = 1'b0;

        // R4 tie
        prio(20, 6, 1); prio(12, 6, 1);
        wr(1, 20, 0); wr(1, 12, 0);
        irq_i[20] = 1'b1; irq_i[12] = 1'b1;
        settle();
        check("R2 ipl level6", int'(ipl_o), 6);
        ack(1, 0, 6, 76, "R4 tie lower index");
        wr(1, 12, 1);
        settle();
        ack(1, 0, 6, 84, "R8 masked loses");
        ack(0, 1, 0, 84, "R7 sw ack top");
        ack(1, 1, 3, 122, "R7 hw precedence");
        check("R10 ipl held", int'(ipl_o), 6);
        irq_i[20] = 1'b0;
        settle();
        check("R10 ipl after drop", int'(ipl_o), 3);

        // R9 mask-all
        wr(2, 0, 1);
        settle();
        check("R9 ipl", int'(ipl_o), 0);
        check("R9 wake", int'(wake_o), 0);
        ack(0, 1, 0, 24, "R9 sw spurious");
        wr(2, 0, 0);
        settle();
        check("R9 restored", int'(ipl_o), 3);

        // R13 fixed source ignores level write
        prio(60, 1, 0); wr(1, 60, 0); irq_i[60] = 1'b1;
        settle();
        check("R13 fixed level", int'(ipl_o), 5);
        wr(3, 7, 0);
        settle();
        check("R13 kind3 no effect", int'(ipl_o), 5);

        // R11 combinational wake
        irq_i = '0;
        settle();
        check("R11 wake idle", int'(wake_o), 0);
        irq_i[7] = 1'b1;
        #1;
        check("R11 wake same cycle", int'(wake_o), 1);
        check("R11 ipl not yet", int'(ipl_o), 0);
        irq_i = '0; irq_i[12] = 1'b1;
        #1;
        check("R8 masked no wake", int'(wake_o), 0);
        @(negedge clk);
        @(negedge clk);
        check("R5 all acks answered", exp_q.size(), 0);
        summary();
    end
endmodule